// File: doc/BRIEF.md
# Bus Cycle Ready Termination Controller

This block decides in which clock the current bus cycle finishes. A cycle is opened by a start strobe together with a few attributes sampled at that edge. These say whether the target is an on-chip peripheral, whether it lies in a chip-select region with programmed wait states, the region's wait count, and whether the region also waits for the external ready pin. While the cycle is open, the block watches the matching termination source. That source is the peripheral's ready, the wait-state countdown, the external ready line, or the countdown followed by the external line. When the source fires, the block raises a one-clock cycle-done pulse.

The ready line on the board is shared and bidirectional. For every cycle that ends inside the chip, the block asserts an active-low local-access indicator. It uses the same level to enable the ready output buffer, so the chip drives the line low in the terminating clock and outside logic can see the cycle end. For cycles that end externally, the buffer stays off and the line is only sampled. All outputs are registered-state driven and synchronous to the bus clock.

Top module: `bus_ready_ctrl`

## Requirements
- R1: After reset, and in every clock with no open cycle, cyc_done is 0 and lba_n, rdy_oe_n and rdy_out_n are all 1.
- R2: A cycle started with cyc_internal=0 and cs_hit=0 ends in the first clock in which rdy_in_n is 0, and lba_n stays 1 throughout.
- R3: A cycle started with cyc_internal=1 ends in the first clock in which periph_rdy is 1. lba_n is 0 from the clock after the start edge through the ending clock.
- R4: A cycle started with cyc_internal=0, cs_hit=1 and cs_ext=0 loads cs_wait (0 to 31) at the start edge. cyc_done is 1 exactly cs_wait clocks after the first open clock (the first open clock counts as 0), and lba_n is 0 during the cycle.
- R5: A cycle started with cs_hit=1 and cs_ext=1 ends in the first clock in which the count has reached zero and rdy_in_n is 0. A low rdy_in_n before the count expires does not end it, and lba_n stays 1.
- R6: During a cycle that ends internally (R3, R4), rdy_in_n has no effect on cyc_done.
- R7: rdy_oe_n equals lba_n in every clock. rdy_out_n is 0 exactly in the ending clock of an internally ended cycle and 1 otherwise.
- R8: lba_n returns to 1 in the clock after the cycle ends.
- R9: cyc_done is 1 for exactly one clock per cycle, and a cyc_start that arrives while a cycle is open is ignored.
- R10: When cyc_internal and cs_hit are both 1 at the start edge, the cycle is treated as an internal peripheral cycle (R3) and the wait count is not used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_start | input | 1 | Opens a bus cycle when none is open |
| cyc_internal | input | 1 | Target is an on-chip peripheral |
| cs_hit | input | 1 | Target lies in a chip-select region with wait states |
| cs_wait | input | 5 | Wait-state count for the region |
| cs_ext | input | 1 | Region also needs the external ready after the count |
| periph_rdy | input | 1 | Ready from the on-chip peripheral, active high |
| rdy_in_n | input | 1 | Sampled level of the shared ready line, active low |
| cyc_done | output | 1 | One-clock cycle termination pulse |
| lba_n | output | 1 | Local-access indicator, active low |
| rdy_oe_n | output | 1 | Ready pad output enable, active low |
| rdy_out_n | output | 1 | Value driven onto the ready line, active low |

## Verification
The external ready line and an internal termination source can both be active in the same clock. The bench provokes this by holding rdy_in_n low through peripheral cycles and wait-state cycles, including the clocks just before the internal source fires. It judges the result by requiring cyc_done only in the clock predicted by the internal source. The same overlap, with the roles reversed, is forced in regions that need both the countdown and the pin: the pin goes low while the count is still running, and the cycle must not end until the count is zero.

// File: rtl/bus_rdy_pkg.sv
`timescale 1ns/1ps
// Package: shared termination-mode encoding for the ready controller.
// Assumes: every module of the block imports this package.
package bus_rdy_pkg;
    typedef enum logic [1:0] {
        TERM_PIN    = 2'd0,   // external ready line ends the cycle
        TERM_PERIPH = 2'd1,   // on-chip peripheral ready ends the cycle
        TERM_COUNT  = 2'd2,   // wait-state countdown alone ends the cycle
        TERM_BOTH   = 2'd3    // countdown, then external ready line
    } term_mode_t;

    // True when the chip itself generates the ending ready.
    function automatic logic is_local(input term_mode_t m);
        return (m == TERM_PERIPH) || (m == TERM_COUNT);
    endfunction
endpackage

// File: rtl/rdy_wait_counter.sv
`timescale 1ns/1ps
// Module: rdy_wait_counter
// Counts down the wait states of a chip-select region. It loads at the
// start edge of a cycle, and then decrements once per clock while the cycle
// is open until it reaches zero, where it holds.
// Assumes: load and run are never both needed in the same clock.
module rdy_wait_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // Load on cycle start, else count down while the cycle is open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Zero detect for the termination logic.
    always_comb begin
        expired = (cnt_q == '0);
    end
endmodule

// File: rtl/rdy_cycle_fsm.sv
`timescale 1ns/1ps
// Module: rdy_cycle_fsm
// Tracks whether a bus cycle is open and which source ends it. It picks the
// source at the start edge, with the peripheral taking priority over a
// chip-select region, and then raises the done pulse when that source fires.
// Assumes: attributes are valid in the same clock as the start strobe.
module rdy_cycle_fsm
    import bus_rdy_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       sel_internal,
    input  logic       sel_cs,
    input  logic       sel_ext,
    input  logic       periph_rdy,
    input  logic       pin_rdy_n,
    input  logic       count_zero,
    output logic       busy,
    output logic       load_cnt,
    output term_mode_t mode,
    output logic       done,
    output logic       local_end
);
    term_mode_t next_mode;
    logic       term_hit;

    // Choose the termination source for a new cycle.
    always_comb begin
        if (sel_internal) begin
            next_mode = TERM_PERIPH;
        end else if (sel_cs) begin
            next_mode = sel_ext ? TERM_BOTH : TERM_COUNT;
        end else begin
            next_mode = TERM_PIN;
        end
    end

    // A new cycle is accepted only when none is open.
    always_comb begin
        load_cnt = start && !busy;
    end

    // Evaluate the selected source; the pin is ignored in local modes.
    always_comb begin
        unique case (mode)
            TERM_PIN:    term_hit = !pin_rdy_n;
            TERM_PERIPH: term_hit = periph_rdy;
            TERM_COUNT:  term_hit = count_zero;
            TERM_BOTH:   term_hit = count_zero && !pin_rdy_n;
            default:     term_hit = 1'b0;
        endcase
        done      = busy && term_hit;
        local_end = done && is_local(mode);
    end

    // Open on accepted start, close after the terminating clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            mode <= TERM_PIN;
        end else if (load_cnt) begin
            busy <= 1'b1;
            mode <= next_mode;
        end else if (done) begin
            busy <= 1'b0;
        end
    end
endmodule

// File: rtl/rdy_pad_ctrl.sv
`timescale 1ns/1ps
// Module: rdy_pad_ctrl
// Produces the local-access indicator and the ready pad controls. The
// indicator is low for the whole of a cycle that ends inside the chip. The
// pad buffer follows it, and the pad drives low in the terminating clock.
// Assumes: busy and mode come from registers, so all outputs are clean.
module rdy_pad_ctrl
    import bus_rdy_pkg::*;
(
    input  logic       busy,
    input  term_mode_t mode,
    input  logic       local_end,
    output logic       lba_n,
    output logic       oe_n,
    output logic       drive_n
);
    // Indicator, buffer enable and driven level, all active low.
    always_comb begin
        lba_n   = !(busy && is_local(mode));
        oe_n    = lba_n;
        drive_n = !local_end;
    end
endmodule

// File: rtl/bus_ready_ctrl.sv
`timescale 1ns/1ps
// Module: bus_ready_ctrl (top)
// Ends each bus cycle on the external ready line, the on-chip peripheral
// ready or the chip-select wait-state countdown. It also controls the
// direction of the shared ready line through the local-access indicator.
// Assumes: WAIT_W wide wait counts; the start strobe is a single clock.
module bus_ready_ctrl #(
    parameter int WAIT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_start,
    input  logic              cyc_internal,
    input  logic              cs_hit,
    input  logic [WAIT_W-1:0] cs_wait,
    input  logic              cs_ext,
    input  logic              periph_rdy,
    input  logic              rdy_in_n,
    output logic              cyc_done,
    output logic              lba_n,
    output logic              rdy_oe_n,
    output logic              rdy_out_n
);
    import bus_rdy_pkg::*;

    logic       busy;
    logic       load_cnt;
    logic       count_zero;
    logic       local_end;
    term_mode_t mode;

    rdy_cycle_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (cyc_start),
        .sel_internal (cyc_internal),
        .sel_cs       (cs_hit),
        .sel_ext      (cs_ext),
        .periph_rdy   (periph_rdy),
        .pin_rdy_n    (rdy_in_n),
        .count_zero   (count_zero),
        .busy         (busy),
        .load_cnt     (load_cnt),
        .mode         (mode),
        .done         (cyc_done),
        .local_end    (local_end)
    );

    rdy_wait_counter #(.CNT_W(WAIT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_cnt),
        .load_val (cs_wait),
        .run      (busy),
        .expired  (count_zero)
    );

    rdy_pad_ctrl u_pad (
        .busy      (busy),
        .mode      (mode),
        .local_end (local_end),
        .lba_n     (lba_n),
        .oe_n      (rdy_oe_n),
        .drive_n   (rdy_out_n)
    );
endmodule

// File: rtl/bus_ready_ctrl_chk.sv
`timescale 1ns/1ps
// Checker: temporal properties of the ready controller, bound to the top.
module bus_ready_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cyc_start,
    input logic cyc_internal,
    input logic rdy_in_n,
    input logic busy,
    input logic cyc_done,
    input logic lba_n,
    input logic rdy_oe_n,
    input logic rdy_out_n
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!cyc_done && lba_n && rdy_out_n));

    assert_pin_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_done && lba_n) |-> !rdy_in_n);

    assert_local_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && !busy && cyc_internal) |=> !lba_n);

    assert_drive_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_out_n |-> (!rdy_oe_n && cyc_done));

    assert_local_end_drives_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_done && !lba_n) |-> !rdy_out_n);

    assert_lba_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> lba_n);

    assert_single_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> !cyc_done);
endmodule

bind bus_ready_ctrl bus_ready_ctrl_chk u_chk (.*);

// File: tb/bus_ready_ctrl_bench.sv
`timescale 1ns/1ps
module bus_ready_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WAIT_W     = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cyc_start = 1'b0;
    logic              cyc_internal = 1'b0;
    logic              cs_hit = 1'b0;
    logic [WAIT_W-1:0] cs_wait = '0;
    logic              cs_ext = 1'b0;
    logic              periph_rdy = 1'b0;
    logic              rdy_in_n = 1'b1;
    logic              cyc_done, lba_n, rdy_oe_n, rdy_out_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_ready_ctrl #(.WAIT_W(WAIT_W)) u_bus_ready_ctrl (.*);

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance to the next low phase; outputs are settled there.
    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // Present a start strobe for one clock, then drop it.
    task automatic open_cycle(input bit intl, input bit cs, input int w, input bit ext);
        cyc_start = 1'b1; cyc_internal = intl; cs_hit = cs;
        cs_wait = WAIT_W'(w); cs_ext = ext;
        step();
        cyc_start = 1'b0; cyc_internal = 1'b0; cs_hit = 1'b0; cs_ext = 1'b0;
        #1;
    endtask

    task automatic check_idle(input string tag);
        chk({tag, " done"}, cyc_done, 0);
        chk({tag, " lba_n"}, lba_n, 1);
        chk({tag, " oe_n"}, rdy_oe_n, 1);
        chk({tag, " out_n"}, rdy_out_n, 1);
    endtask

    task automatic t_reset();
        check_idle("R1 reset");
    endtask

    task automatic t_pin_cycle();
        rdy_in_n = 1'b1;
        open_cycle(0, 0, 0, 0);
        for (int i = 0; i < 3; i++) begin
            chk("R2 wait done", cyc_done, 0);
            chk("R2 lba_n", lba_n, 1);
            chk("R7 oe_n ext", rdy_oe_n, 1);
            step();
        end
        rdy_in_n = 1'b0; #1;
        chk("R2 end done", cyc_done, 1);
        chk("R7 out_n ext end", rdy_out_n, 1);
        step();
        chk("R9 single pulse", cyc_done, 0);
        rdy_in_n = 1'b1; #1;
        check_idle("R1 after pin");
    endtask

    task automatic t_periph_cycle();
        rdy_in_n = 1'b0; periph_rdy = 1'b0;
        open_cycle(1, 0, 0, 0);
        for (int i = 0; i < 2; i++) begin
            chk("R6 pin ignored periph", cyc_done, 0);
            chk("R3 lba_n low", lba_n, 0);
            chk("R7 oe_n follows", rdy_oe_n, 0);
            chk("R7 out_n idle", rdy_out_n, 1);
            step();
        end
        periph_rdy = 1'b1; #1;
        chk("R3 end done", cyc_done, 1);
        chk("R7 out_n drives", rdy_out_n, 0);
        chk("R3 lba_n at end", lba_n, 0);
        step();
        periph_rdy = 1'b0; #1;
        chk("R8 lba_n released", lba_n, 1);
        chk("R7 oe_n released", rdy_oe_n, 1);
        chk("R1 idle pin low", cyc_done, 0);
        rdy_in_n = 1'b1;
        step();
    endtask

    task automatic t_count_cycle(input int w);
        open_cycle(0, 1, w, 0);
        for (int i = 0; i <= w; i++) begin
            rdy_in_n = i[0]; #1;  // R6: toggling pin must not matter
            chk($sformatf("R4 w=%0d clk %0d done", w, i), cyc_done, (i == w) ? 1 : 0);
            chk($sformatf("R4 w=%0d lba_n", w), lba_n, 0);
            if (i == w) chk("R7 out_n count end", rdy_out_n, 0);
            step();
        end
        chk("R8 lba_n after count", lba_n, 1);
        chk("R9 no second pulse", cyc_done, 0);
        rdy_in_n = 1'b1;
        step();
    endtask

    task automatic t_both_cycle();
        rdy_in_n = 1'b1;
        open_cycle(0, 1, 2, 1);
        for (int i = 0; i < 5; i++) begin
            rdy_in_n = (i == 1 || i == 4) ? 1'b0 : 1'b1; #1;
            chk($sformatf("R5 clk %0d done", i), cyc_done, (i == 4) ? 1 : 0);
            chk("R5 lba_n high", lba_n, 1);
            step();
        end
        rdy_in_n = 1'b1; #1;
        check_idle("R5 after");
    endtask

    task automatic t_priority();
        periph_rdy = 1'b1; rdy_in_n = 1'b1;
        open_cycle(1, 1, 5, 0);
        chk("R10 periph wins", cyc_done, 1);
        chk("R10 lba_n", lba_n, 0);
        step();
        periph_rdy = 1'b0; #1;
        check_idle("R10 after");
    endtask

    task automatic t_busy_start();
        rdy_in_n = 1'b1;
        open_cycle(0, 0, 0, 0);
        cyc_start = 1'b1; cyc_internal = 1'b1;
        step();
        cyc_start = 1'b0; cyc_internal = 1'b0; #1;
        chk("R9 start ignored lba_n", lba_n, 1);
        rdy_in_n = 1'b0; #1;
        chk("R9 pin end", cyc_done, 1);
        step();
        chk("R9 no restart done", cyc_done, 0);
        chk("R9 no restart lba_n", lba_n, 1);
        rdy_in_n = 1'b1;
        step();
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_pin_cycle();
        t_periph_cycle();
        t_count_cycle(0);
        t_count_cycle(1);
        t_count_cycle(5);
        t_count_cycle(31);
        t_both_cycle();
        t_priority();
        t_busy_start();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule